// File: doc/BRIEF.md
# Operand Dependency Hazard Detector

This block decides whether an instruction that is about to issue has to wait for the result of the instruction issued just before it. Both instructions arrive already decoded. For the earlier instruction it sees a valid bit, a destination register with its addressing kind, and a bit saying it writes the condition flag. For the later instruction it sees a valid bit, its own destination with kind, up to `NUM_SRC` source operands (each with a kind and a register number), and a bit saying it reads the condition flag.

Addressing kind changes the outcome. A register used as the base of a displacement address is not the same as a register used directly. A store's base register is the "destination" of the store, but a later plain register read never depends on it. Two memory accesses in a row always depend on each other, so a store finishes before the next memory access. Flag producer/consumer pairs always depend on each other. The later instruction's own displacement-base destination counts as a source, so a load followed by a store through the loaded base register is caught.

The single output is a hazard bit. The `REG_OUT` parameter selects whether it is registered or combinational. Decoding and stall insertion belong to the surrounding pipeline.

Top module: `opnd_hazard_chk`

## Requirements
- R1: `hazard_o` is 0 whenever `prv_valid` or `nxt_valid` is 0, whatever the other inputs are.
- R2: When both are valid and `prv_flag_wr` and `nxt_flag_rd` are both 1, `hazard_o` is 1.
- R3: A previous destination kind of 0 (none) never causes a register hazard.
- R4: A source kind of 0 (immediate) never causes a hazard, and kind code 3 is treated the same as immediate.
- R5: A previous direct destination (kind 1) and a direct source (kind 1) cause a hazard only when the register numbers are equal.
- R6: A previous displacement destination (kind 2) and a direct source never cause a hazard.
- R7: A previous direct destination and a displacement-base source (kind 2) cause a hazard only when the register numbers are equal.
- R8: A previous displacement destination and any displacement-base source cause a hazard, whatever the register numbers are.
- R9: The next instruction's destination is compared as a displacement-base source when its kind is 2. A direct or absent next destination is not compared.
- R10: With `ZERO_MATCH`=0 (the default), an equal register number of 0 does not count as a match in R5 and R7. R8 still applies.
- R11: With `REG_OUT`=1 (the default), `hazard_o` shows the verdict for the inputs present at one rising clock edge, starting just after that edge. It is 0 during and right after reset.

Source operand j uses bits `[2j+1:2j]` of `nxt_src_kind` and bits `[5j+4:5j]` of `nxt_src_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prv_valid | input | 1 | Earlier instruction slot holds an instruction |
| prv_dst_kind | input | 2 | Earlier destination kind: 0 none, 1 direct, 2 displacement base |
| prv_dst_reg | input | REG_W | Earlier destination register number |
| prv_flag_wr | input | 1 | Earlier instruction writes the condition flag |
| nxt_valid | input | 1 | Later instruction slot holds an instruction |
| nxt_dst_kind | input | 2 | Later destination kind, same coding |
| nxt_dst_reg | input | REG_W | Later destination register number |
| nxt_src_kind | input | 2*NUM_SRC | Source kinds: 0 immediate, 1 direct, 2 displacement base, 3 as immediate |
| nxt_src_reg | input | REG_W*NUM_SRC | Source register numbers |
| nxt_flag_rd | input | 1 | Later instruction reads the condition flag |
| hazard_o | output | 1 | Later instruction must wait |

## Verification
In the default registered build, every verdict is due exactly one rising edge after its inputs are applied. The bench applies each stimulus on a falling edge. It then waits through the next rising edge and compares the output at the falling edge after that, so each stimulus is held for a full cycle and is checked on its own. The sweeps run over every combination of the two destination kinds, all four source-kind codes in each of the three source slots, and several register layouts that include register 0. Valid and flag bits are swept separately. The expected value comes from a rule-by-rule model in the bench.

// File: rtl/opnd_hazard_pkg.sv
package opnd_hazard_pkg;
    localparam logic [1:0] KIND_NONE   = 2'd0;
    localparam logic [1:0] KIND_DIRECT = 2'd1;
    localparam logic [1:0] KIND_DISP   = 2'd2;

    typedef struct packed {
        logic hazard;
    } haz_state_t;
endpackage

// File: rtl/opnd_src_cmp.sv
module opnd_src_cmp
    import opnd_hazard_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter bit ZERO_MATCH = 1'b0
) (
    input  logic [1:0]       dst_kind,
    input  logic [REG_W-1:0] dst_reg,
    input  logic [1:0]       src_kind,
    input  logic [REG_W-1:0] src_reg,
    output logic             match_o
);
    logic same_reg;
    logic src_is_reg;

    always_comb begin
        same_reg   = (src_reg == dst_reg) && (ZERO_MATCH || (src_reg != '0));
        src_is_reg = (src_kind == KIND_DIRECT) || (src_kind == KIND_DISP);
        match_o    = 1'b0;
        case (dst_kind)
            KIND_DIRECT: match_o = src_is_reg && same_reg;
            KIND_DISP:   match_o = (src_kind == KIND_DISP);
            default:     match_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/opnd_flag_cmp.sv
module opnd_flag_cmp (
    input  logic prv_wr,
    input  logic nxt_rd,
    output logic hit_o
);
    always_comb hit_o = prv_wr && nxt_rd;
endmodule

// File: rtl/opnd_hazard_chk.sv
module opnd_hazard_chk
    import opnd_hazard_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int NUM_SRC    = 3,
    parameter bit ZERO_MATCH = 1'b0,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prv_valid,
    input  logic [1:0]               prv_dst_kind,
    input  logic [REG_W-1:0]         prv_dst_reg,
    input  logic                     prv_flag_wr,
    input  logic                     nxt_valid,
    input  logic [1:0]               nxt_dst_kind,
    input  logic [REG_W-1:0]         nxt_dst_reg,
    input  logic [2*NUM_SRC-1:0]     nxt_src_kind,
    input  logic [REG_W*NUM_SRC-1:0] nxt_src_reg,
    input  logic                     nxt_flag_rd,
    output logic                     hazard_o
);
    localparam int NUM_CMP = NUM_SRC + 1;

    logic [NUM_CMP-1:0] op_hit;
    logic               flag_hit;
    haz_state_t         st_d, st_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
            logic [1:0]       k;
            logic [REG_W-1:0] r;
            if (gi < NUM_SRC) begin : g_src
                assign k = nxt_src_kind[2*gi +: 2];
                assign r = nxt_src_reg[REG_W*gi +: REG_W];
            end else begin : g_dst
                // store base of the later instruction acts as a read
                assign k = (nxt_dst_kind == KIND_DISP) ? KIND_DISP : KIND_NONE;
                assign r = nxt_dst_reg;
            end
            opnd_src_cmp #(
                .REG_W      (REG_W),
                .ZERO_MATCH (ZERO_MATCH)
            ) u_cmp (
                .dst_kind (prv_dst_kind),
                .dst_reg  (prv_dst_reg),
                .src_kind (k),
                .src_reg  (r),
                .match_o  (op_hit[gi])
            );
        end
    endgenerate

    opnd_flag_cmp u_flag (
        .prv_wr (prv_flag_wr),
        .nxt_rd (nxt_flag_rd),
        .hit_o  (flag_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.hazard = prv_valid && nxt_valid && (flag_hit || (|op_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (REG_OUT) begin : g_reg
            assign hazard_o = st_q.hazard;
        end else begin : g_comb
            assign hazard_o = st_d.hazard;
        end
    endgenerate

    logic any_disp_src;
    always_comb begin
        any_disp_src = (nxt_dst_kind == KIND_DISP);
        for (int j = 0; j < NUM_SRC; j++)
            if (nxt_src_kind[2*j +: 2] == KIND_DISP) any_disp_src = 1'b1;
    end

    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(prv_valid && nxt_valid) |-> !st_d.hazard); // R1
    AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (prv_valid && nxt_valid && prv_flag_wr && nxt_flag_rd) |-> st_d.hazard); // R2
    AST_NO_DEST_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (prv_dst_kind == KIND_NONE) |-> (op_hit == '0)); // R3
    AST_MEM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (prv_valid && nxt_valid && prv_dst_kind == KIND_DISP && any_disp_src) |-> st_d.hazard); // R8
    AST_STORE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (prv_valid && nxt_valid && prv_dst_kind == KIND_DISP && !any_disp_src
         && !(prv_flag_wr && nxt_flag_rd)) |-> !st_d.hazard); // R6
    generate
        if (REG_OUT) begin : g_ast_lat
            AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (hazard_o == $past(st_d.hazard))); // R11
        end
    endgenerate
endmodule

// File: tb/opnd_hazard_chk_tb.sv
module opnd_hazard_chk_tb;
    localparam int RW = 5;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prv_valid = 0, prv_flag_wr = 0, nxt_valid = 0, nxt_flag_rd = 0;
    logic [1:0]    prv_dst_kind = 0, nxt_dst_kind = 0;
    logic [RW-1:0] prv_dst_reg = 0, nxt_dst_reg = 0;
    logic [2*NS-1:0]  nxt_src_kind = 0;
    logic [RW*NS-1:0] nxt_src_reg = 0;
    logic          hazard_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    opnd_hazard_chk u_dut (
        .clk, .rst_n, .prv_valid, .prv_dst_kind, .prv_dst_reg, .prv_flag_wr,
        .nxt_valid, .nxt_dst_kind, .nxt_dst_reg, .nxt_src_kind, .nxt_src_reg,
        .nxt_flag_rd, .hazard_o
    );

    function automatic bit op_rule(logic [1:0] dk, logic [RW-1:0] dr,
                                   logic [1:0] sk, logic [RW-1:0] sr);
        bit eq;
        eq = (dr == sr) && (sr != 0);            // R10
        if (sk == 2'd0 || sk == 2'd3) return 0;  // R4
        if (dk == 2'd1) return eq;               // R5, R7
        if (dk == 2'd2) return (sk == 2'd2);     // R6, R8
        return 0;                                // R3
    endfunction

    function automatic bit model();
        bit h;
        if (!(prv_valid && nxt_valid)) return 0; // R1
        if (prv_flag_wr && nxt_flag_rd) return 1; // R2
        h = 0;
        for (int j = 0; j < NS; j++)
            h |= op_rule(prv_dst_kind, prv_dst_reg,
                         nxt_src_kind[2*j +: 2], nxt_src_reg[RW*j +: RW]);
        if (nxt_dst_kind == 2'd2)                 // R9
            h |= op_rule(prv_dst_kind, prv_dst_reg, 2'd2, nxt_dst_reg);
        return h;
    endfunction

    task automatic check(string tag, bit exp);
        n_tests++;
        if (hazard_o !== exp) begin
            n_fail++;
            $display("FAIL %s: hazard_o=%b expected=%b (pk=%0d pr=%0d nk=%0d nr=%0d sk=%b sr=%h)",
                     tag, hazard_o, exp, prv_dst_kind, prv_dst_reg, nxt_dst_kind,
                     nxt_dst_reg, nxt_src_kind, nxt_src_reg);
        end
    endtask

    // inputs are set on a falling edge; verdict sampled one full cycle later
    task automatic apply(string tag);
        bit e;
        e = model();
        @(negedge clk);
        check(tag, e);
    endtask

    task automatic set_src(int j, logic [1:0] k, logic [RW-1:0] r);
        nxt_src_kind[2*j +: 2] = k;
        nxt_src_reg[RW*j +: RW] = r;
    endtask

    initial begin
        logic [RW-1:0] regs [4];
        regs[0] = 5'd0; regs[1] = 5'd1; regs[2] = 5'd5; regs[3] = 5'd31;

        @(negedge clk);
        check("R11 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", 1'b0);

        // directed cases
        prv_valid = 1; nxt_valid = 1;
        prv_dst_kind = 2'd1; prv_dst_reg = 5'd7;
        set_src(0, 2'd1, 5'd7); apply("R5 equal direct");
        check("R5 equal direct value", 1'b1);
        set_src(0, 2'd1, 5'd6); apply("R5 unequal direct");
        set_src(0, 2'd2, 5'd7); apply("R7 equal base");
        set_src(0, 2'd0, 5'd7); apply("R4 immediate");
        set_src(0, 2'd3, 5'd7); apply("R4 code3");
        set_src(0, 2'd0, 5'd0);
        prv_dst_kind = 2'd2;
        set_src(1, 2'd1, 5'd7); apply("R6 store then direct");
        check("R6 value", 1'b0);
        set_src(1, 2'd2, 5'd9); apply("R8 store then mem");
        check("R8 value", 1'b1);
        set_src(1, 2'd0, 5'd0);
        prv_dst_kind = 2'd1; prv_dst_reg = 5'd4;
        nxt_dst_kind = 2'd2; nxt_dst_reg = 5'd4; apply("R9 load then store base");
        check("R9 value", 1'b1);
        nxt_dst_kind = 2'd1; apply("R9 direct dest ignored");
        check("R9 ignored value", 1'b0);
        prv_dst_reg = 5'd0; set_src(2, 2'd1, 5'd0); apply("R10 zero reg");
        check("R10 value", 1'b0);
        prv_dst_kind = 2'd0; apply("R3 no dest");

        // valid/flag sweep with a register conflict also present
        for (int m = 0; m < 16; m++) begin
            prv_valid = m[0]; nxt_valid = m[1]; prv_flag_wr = m[2]; nxt_flag_rd = m[3];
            prv_dst_kind = 2'd1; prv_dst_reg = 5'd3; set_src(2, 2'd1, m[0] ? 5'd3 : 5'd2);
            apply((m[0] && m[1]) ? "R2 flag sweep" : "R1 valid sweep");
        end

        // register-rule sweep
        prv_valid = 1; nxt_valid = 1; prv_flag_wr = 0; nxt_flag_rd = 0;
        for (int pk = 0; pk < 4; pk++)
            for (int pr = 0; pr < 4; pr++)
                for (int nk = 0; nk < 3; nk++)
                    for (int sc = 0; sc < 64; sc++)
                        for (int rp = 0; rp < 4; rp++) begin
                            prv_dst_kind = 2'(pk);
                            prv_dst_reg  = regs[pr];
                            nxt_dst_kind = 2'(nk);
                            nxt_dst_reg  = regs[(rp + 3) % 4];
                            for (int j = 0; j < NS; j++)
                                set_src(j, 2'((sc >> (2*j)) & 3), regs[(rp + j) % 4]);
                            apply("R3/R4/R5/R6/R7/R8/R9/R10 sweep");
                        end

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule